// File: doc/BRIEF.md
# 10 Mb/s Manchester Transmitter with Jabber Guard

This block sits between the transmit side of a media independent interface and the 10 Mb/s twisted-pair line driver. While transmit enable is high it takes one 4-bit nibble at a time from the MAC, sends the nibble's bits least significant first, and Manchester-codes each bit onto a pair of complementary digital rails. When a frame ends it holds the line high for two bit times to mark the end of transmission, and then releases both rails. While the line is idle it sends short normal link pulses at a fixed interval.

A jabber guard runs alongside the transmitter. It measures how long transmit enable has stayed high without a break. If that time passes a limit, the guard cuts the line drive at once and raises a jabber flag. The flag drops only after transmit enable has stayed low for a full unjab interval. Any assertion of transmit enable during that wait starts the interval again. All timing is given in clock cycles through parameters: the half-bit length, the link pulse period and width, the jabber limit and the unjab interval. The defaults assume a 100 MHz clock, with a 50 ms jabber limit, a 500 ms unjab interval and a link pulse every 16 ms.

The transmit controller has four states. TX_IDLE sends link pulses and moves to TX_SEND when transmit enable is seen. TX_SEND moves to TX_ETD at a nibble boundary where transmit enable is low. TX_ETD moves back to TX_IDLE when the delimiter time has run out. Every state moves to TX_HALT while jabber is active, and TX_HALT moves to TX_IDLE once jabber clears. The jabber guard has two states. JB_CLEAR moves to JB_TRIPPED when the activity count reaches its limit. JB_TRIPPED moves back to JB_CLEAR when the quiet count reaches its limit.

Top module: `mtx10_xmit`

## Requirements
- R1: While a frame is being sent, each bit takes two halves of HALF_CLKS cycles each. A 1 drives tx_p low in the first half and high in the second half. A 0 drives tx_p high, then low. tx_n is the complement of tx_p, and the two rails are never high together.
- R2: The nibble on txd is captured at the clock edge that ends a cycle in which nib_ack is high. Its bits go out in the order txd[0], txd[1], txd[2], txd[3].
- R3: nib_ack is high in a cycle only when tx_en is high and jabber is low, and the controller is either in idle or in the last cycle of a nibble. The next nibble then starts with no gap.
- R4: tx_en is sampled only in the last cycle of each nibble. If it drops partway through a nibble, that nibble is still sent in full.
- R5: After the last nibble, tx_p=1 and tx_n=0 for 4*HALF_CLKS cycles (two bit times). Both rails are then 0.
- R6: In idle, tx_p=1 and tx_n=0 for NLP_WIDTH cycles ending at the NLP_PERIOD-th clock edge after idle was entered or reset released, and this repeats every NLP_PERIOD cycles. At all other idle times both rails are 0.
- R7: No link pulse appears while a frame is being sent, during the delimiter, or while jabber is active. The pulse timer restarts on return to idle.
- R8: jabber rises at the JAB_LIMIT-th consecutive clock edge at which tx_en is high. In that same cycle both rails fall to 0.
- R9: While jabber is high, tx_en has no effect: nib_ack stays 0 and both rails stay 0.
- R10: jabber falls at the UNJAB_LIMIT-th consecutive clock edge at which tx_en is low. Any cycle with tx_en high restarts that count.
- R11: During reset, tx_p, tx_n, jabber and nib_ack are all 0 when tx_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| txd | input | 4 | Transmit nibble from the MAC |
| nib_ack | output | 1 | The nibble on txd is taken at the next edge |
| tx_p | output | 1 | Positive line rail |
| tx_n | output | 1 | Negative line rail |
| jabber | output | 1 | Jabber state active; line not driven |

## Verification
A wrong bit index or half-phase shows on tx_p within one half-bit (five cycles at the default timing). This is why each half of every bit in a frame is sampled in its middle, across nibbles with many different bit patterns. Errors in the jabber or unjab counters are only visible at the edge where the flag should change. The bench therefore samples jabber one cycle before that edge and one cycle after it, and also restarts the unjab wait once to expose a counter that fails to clear. An error in the link pulse timer may not show until the next pulse, up to a full period later. To catch it, the bench times both edges of the first pulse and starts a frame just before a second pulse is due.

// File: rtl/mtx10_pkg.sv
package mtx10_pkg;

    localparam int NIB_W    = 4;
    localparam int ETD_BITS = 2;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_ETD,
        TX_HALT
    } tx_state_e;

    typedef enum logic {
        JB_CLEAR,
        JB_TRIPPED
    } jab_state_e;

endpackage

// File: rtl/mtx10_jabber.sv
module mtx10_jabber
    import mtx10_pkg::*;
#(
    parameter int JAB_LIMIT   = 5_000_000,
    parameter int UNJAB_LIMIT = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic jab_active
);

    localparam int AC_W = (JAB_LIMIT > 1) ? $clog2(JAB_LIMIT + 1) : 1;
    localparam int QC_W = (UNJAB_LIMIT > 1) ? $clog2(UNJAB_LIMIT + 1) : 1;
    localparam logic [AC_W-1:0] ACT_LAST   = AC_W'(JAB_LIMIT - 1);
    localparam logic [QC_W-1:0] QUIET_LAST = QC_W'(UNJAB_LIMIT - 1);

    jab_state_e      state_q, state_d;
    logic [AC_W-1:0] act_cnt;
    logic [QC_W-1:0] quiet_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= JB_CLEAR;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            JB_CLEAR: begin
                if (tx_en && (act_cnt == ACT_LAST)) state_d = JB_TRIPPED;
            end
            JB_TRIPPED: begin
                if (!tx_en && (quiet_cnt == QUIET_LAST)) state_d = JB_CLEAR;
            end
        endcase
    end

    // activity and quiet counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cnt   <= '0;
            quiet_cnt <= '0;
        end else begin
            if (state_q == JB_CLEAR && state_d == JB_CLEAR && tx_en)
                act_cnt <= act_cnt + 1'b1;
            else
                act_cnt <= '0;

            if (state_q == JB_TRIPPED && state_d == JB_TRIPPED && !tx_en)
                quiet_cnt <= quiet_cnt + 1'b1;
            else
                quiet_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        jab_active = (state_q == JB_TRIPPED);
    end

endmodule

// File: rtl/mtx10_nlp.sv
module mtx10_nlp #(
    parameter int NLP_PERIOD = 1_600_000,
    parameter int NLP_WIDTH  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic pulse
);

    localparam int PC_W = (NLP_PERIOD > 1) ? $clog2(NLP_PERIOD) : 1;
    localparam logic [PC_W-1:0] P_LAST  = PC_W'(NLP_PERIOD - 1);
    localparam logic [PC_W-1:0] P_START = PC_W'(NLP_PERIOD - NLP_WIDTH);

    logic [PC_W-1:0] cnt;

    // interval counter, held at zero while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!enable)        cnt <= '0;
        else if (cnt == P_LAST)  cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // pulse sits at the end of each interval
    always_comb begin
        pulse = enable && (cnt >= P_START);
    end

endmodule

// File: rtl/mtx10_ctrl.sv
module mtx10_ctrl
    import mtx10_pkg::*;
#(
    parameter int HALF_CLKS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    input  logic             jab_active,
    input  logic             nlp_pulse,
    output logic             nib_ack,
    output logic             line_p,
    output logic             line_n,
    output logic             idle_st
);

    localparam int HC_W     = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam int ETD_CLKS = ETD_BITS * 2 * HALF_CLKS;
    localparam int EC_W     = $clog2(ETD_CLKS);
    localparam int BI_W     = $clog2(NIB_W);
    localparam logic [HC_W-1:0] HALF_LAST = HC_W'(HALF_CLKS - 1);
    localparam logic [EC_W-1:0] ETD_LAST  = EC_W'(ETD_CLKS - 1);
    localparam logic [BI_W-1:0] BIT_LAST  = BI_W'(NIB_W - 1);

    tx_state_e        state_q, state_d;
    logic [HC_W-1:0]  half_cnt;
    logic             late_half;
    logic [BI_W-1:0]  bit_idx;
    logic [NIB_W-1:0] nib_q;
    logic [EC_W-1:0]  etd_cnt;
    logic             half_end, nib_end, etd_done, load;
    logic             drive_on, drive_lvl;

    assign half_end = (half_cnt == HALF_LAST);
    assign nib_end  = half_end && late_half && (bit_idx == BIT_LAST);
    assign etd_done = (etd_cnt == ETD_LAST);
    assign load     = tx_en && !jab_active &&
                      ((state_q == TX_IDLE) || (state_q == TX_SEND && nib_end));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (jab_active) begin
            state_d = TX_HALT;
        end else begin
            unique case (state_q)
                TX_IDLE: if (tx_en)             state_d = TX_SEND;
                TX_SEND: if (nib_end && !tx_en) state_d = TX_ETD;
                TX_ETD:  if (etd_done)          state_d = TX_IDLE;
                TX_HALT:                        state_d = TX_IDLE;
            endcase
        end
    end

    // bit timing and nibble hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt  <= '0;
            late_half <= 1'b0;
            bit_idx   <= '0;
            nib_q     <= '0;
            etd_cnt   <= '0;
        end else begin
            if (load) begin
                nib_q     <= txd;
                half_cnt  <= '0;
                late_half <= 1'b0;
                bit_idx   <= '0;
            end else if (state_q == TX_SEND) begin
                if (half_end) begin
                    half_cnt  <= '0;
                    late_half <= ~late_half;
                    if (late_half) bit_idx <= bit_idx + 1'b1;
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                end
            end

            if (state_q == TX_ETD) etd_cnt <= etd_cnt + 1'b1;
            else                   etd_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        drive_on  = 1'b0;
        drive_lvl = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                drive_on  = nlp_pulse;
                drive_lvl = 1'b1;
            end
            TX_SEND: begin
                drive_on  = 1'b1;
                drive_lvl = late_half ? nib_q[bit_idx] : ~nib_q[bit_idx];
            end
            TX_ETD: begin
                drive_on  = 1'b1;
                drive_lvl = 1'b1;
            end
            TX_HALT: begin
                drive_on  = 1'b0;
                drive_lvl = 1'b0;
            end
        endcase
        line_p  = drive_on && drive_lvl && !jab_active;
        line_n  = drive_on && !drive_lvl && !jab_active;
        nib_ack = load;
        idle_st = (state_q == TX_IDLE);
    end

endmodule

// File: rtl/mtx10_xmit.sv
module mtx10_xmit
    import mtx10_pkg::*;
#(
    parameter int HALF_CLKS   = 5,
    parameter int NLP_PERIOD  = 1_600_000,
    parameter int NLP_WIDTH   = 10,
    parameter int JAB_LIMIT   = 5_000_000,
    parameter int UNJAB_LIMIT = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic [3:0] txd,
    output logic       nib_ack,
    output logic       tx_p,
    output logic       tx_n,
    output logic       jabber
);

    logic jab_active;
    logic idle_st;
    logic nlp_en;
    logic nlp_pulse;

    assign nlp_en = idle_st && !jab_active;
    assign jabber = jab_active;

    mtx10_jabber #(
        .JAB_LIMIT   (JAB_LIMIT),
        .UNJAB_LIMIT (UNJAB_LIMIT)
    ) u_jabber (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .jab_active (jab_active)
    );

    mtx10_nlp #(
        .NLP_PERIOD (NLP_PERIOD),
        .NLP_WIDTH  (NLP_WIDTH)
    ) u_nlp (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (nlp_en),
        .pulse  (nlp_pulse)
    );

    mtx10_ctrl #(
        .HALF_CLKS (HALF_CLKS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .txd        (txd),
        .jab_active (jab_active),
        .nlp_pulse  (nlp_pulse),
        .nib_ack    (nib_ack),
        .line_p     (tx_p),
        .line_n     (tx_n),
        .idle_st    (idle_st)
    );

endmodule

// File: rtl/mtx10_xmit_sva.sv
module mtx10_xmit_sva (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic nib_ack,
    input logic tx_p,
    input logic tx_n,
    input logic jabber
);

    // R1: the rails are never both high
    p_one_rail_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_p && tx_n));

    // R3: a nibble is taken only while enable is high
    p_ack_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nib_ack |-> tx_en);

    // R8: jabber only trips after enable was high
    p_jab_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jabber) |-> $past(tx_en));

    // R8: line released while jabber is active
    p_jab_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> (!tx_p && !tx_n));

    // R9: no nibble accepted during jabber
    p_jab_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> !nib_ack);

    // R10: jabber clears only after an idle enable
    p_jab_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jabber) |-> !$past(tx_en));

endmodule

bind mtx10_xmit mtx10_xmit_sva u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .nib_ack (nib_ack),
    .tx_p    (tx_p),
    .tx_n    (tx_n),
    .jabber  (jabber)
);

// File: tb/mtx10_xmit_tb.sv
module mtx10_xmit_tb;

    localparam int HALF  = 5;
    localparam int NLP_P = 2000;
    localparam int NLP_W = 10;
    localparam int JAB   = 3000;
    localparam int UNJAB = 4000;
    localparam int NVEC  = 8;

    // {nibble, tx_p per half: bit0 first half at [7]}
    localparam logic [11:0] VEC [NVEC] = '{
        12'h0_AA, 12'hF_55, 12'h5_66, 12'hA_99,
        12'h1_6A, 12'h8_A9, 12'h3_5A, 12'hC_A5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       nib_ack, tx_p, tx_n, jabber;

    int nchk = 0;
    int nbad = 0;

    always #5 clk = ~clk;

    mtx10_xmit #(
        .HALF_CLKS   (HALF),
        .NLP_PERIOD  (NLP_P),
        .NLP_WIDTH   (NLP_W),
        .JAB_LIMIT   (JAB),
        .UNJAB_LIMIT (UNJAB)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .txd     (txd),
        .nib_ack (nib_ack),
        .tx_p    (tx_p),
        .tx_n    (tx_n),
        .jabber  (jabber)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        nchk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int seen;

        // R11: reset state
        ticks(3);
        chk("R11 tx_p", tx_p, 0);
        chk("R11 tx_n", tx_n, 0);
        chk("R11 jabber", jabber, 0);
        chk("R11 nib_ack", nib_ack, 0);
        rst_n = 1'b1;

        // R6: first link pulse placement and width
        ticks(NLP_P - NLP_W - 1);
        chk("R6 before pulse", tx_p, 0);
        ticks(1);
        chk("R6 pulse start p", tx_p, 1);
        chk("R6 pulse start n", tx_n, 0);
        ticks(NLP_W - 1);
        chk("R6 pulse end", tx_p, 1);
        ticks(1);
        chk("R6 after pulse", tx_p, 0);

        // start a frame just before the second pulse would fall due
        ticks(NLP_P - NLP_W - 5);
        tx_en = 1'b1;
        txd   = VEC[0][11:8];
        #1;
        chk("R3 ack at start", nib_ack, 1);

        // vector table walk: R1 R2 R4 R7
        for (int j = 0; j < NVEC; j++) begin
            for (int s = 0; s < 8; s++) begin
                for (int m = 0; m < HALF; m++) begin
                    @(negedge clk);
                    if (s == 0 && m == 0) begin
                        if (j < NVEC - 1) txd = VEC[j + 1][11:8];
                        else              tx_en = 1'b0;
                    end
                    if (m == HALF / 2) begin
                        chk((j == NVEC - 1) ? "R4 R1 half tx_p" : "R1 R2 R7 half tx_p",
                            tx_p, int'(VEC[j][7 - s]));
                        chk("R1 half tx_n", tx_n, int'(!VEC[j][7 - s]));
                    end
                    if (s == 7 && m == HALF - 1)
                        chk("R3 R4 ack at boundary", nib_ack, (j < NVEC - 1) ? 1 : 0);
                end
            end
        end

        // R5: end-of-transmission delimiter
        for (int e = 0; e < 4 * HALF; e++) begin
            @(negedge clk);
            if (e == HALF / 2 || e == 4 * HALF - 1) begin
                chk("R5 delimiter p", tx_p, 1);
                chk("R5 delimiter n", tx_n, 0);
            end
        end
        @(negedge clk);
        chk("R5 released p", tx_p, 0);
        chk("R5 released n", tx_n, 0);
        ticks(100);
        chk("R7 no early pulse after frame", tx_p, 0);

        // R8: jabber trip timing
        tx_en = 1'b1;
        txd   = 4'h6;
        ticks(JAB - 1);
        chk("R8 not yet", jabber, 0);
        chk("R8 line driven", int'(tx_p ^ tx_n), 1);
        ticks(1);
        chk("R8 tripped", jabber, 1);
        chk("R8 line off p", tx_p, 0);
        chk("R8 line off n", tx_n, 0);

        // R9: enable ignored while jabbed
        ticks(20);
        chk("R9 no ack", nib_ack, 0);
        chk("R9 still off", int'(tx_p | tx_n), 0);

        // R10: unjab wait with a restart
        tx_en = 1'b0;
        ticks(1000);
        chk("R10 held", jabber, 1);
        tx_en = 1'b1;
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (nib_ack) seen++;
        end
        chk("R9 no ack during restart", seen, 0);
        tx_en = 1'b0;
        seen = 0;
        for (int i = 0; i < UNJAB - 1; i++) begin
            @(negedge clk);
            if (tx_p || tx_n) seen++;
        end
        chk("R10 held to limit", jabber, 1);
        chk("R7 no pulse while jabbed", seen, 0);
        ticks(1);
        chk("R10 released", jabber, 0);

        // traffic accepted again once idle
        ticks(1);
        tx_en = 1'b1;
        txd   = 4'h9;
        #1;
        chk("R3 ack after unjab", nib_ack, 1);
        @(negedge clk);
        tx_en = 1'b0;
        ticks(8 * HALF + 4 * HALF + 2);
        chk("R5 idle after short frame", int'(tx_p | tx_n), 0);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule